// File: doc/BRIEF.md
# Operand Effective-Address Generator with Banked Registers

This block turns one 6-bit operand specifier of a byte-addressable 16-bit core into a complete memory access description. The core keeps its sixteen working registers in RAM, so even a plain register operand becomes a RAM address. That address is formed from a bank base register. Pointer-based forms use eight pointer registers, numbered 8 through 15. Register 15 acts as the stack pointer and gets push and pop behaviour.

Each cycle with `op_valid` high, the block samples the following inputs:
- the specifier,
- the access direction,
- the extension word that follows the instruction (a direct address, an index or an immediate value),
- the bank base,
- the eight pointer values.

One clock later it presents these outputs:
- the RAM address,
- the access size,
- the byte-lane write enables,
- a pointer write-back (index and new value),
- whether the extension word is used,
- whether RAM is touched at all,
- an illegal-use flag,
- the extra clock count for the operand.

The instruction sequencer walks operands in order: the source first, then the destination. Each operand that reports `ext_used` consumes the next word of the instruction stream.

Top module: `oag_top`

## Requirements
- R1: Specifier `00rrrr` is register mode. The address is `{bank_base[15:5], rrrr, 0}`, so base bits 4:0 have no effect. The access is always word sized, with no pointer update and 0 extra clocks. With base 0x0100, register 14 maps to 0x011C.
- R2: Specifier `011111` is immediate mode. The operand is the extension word: `ext_used`=1, `mem_access`=0, address 0, and 0 extra clocks. As a write destination it raises `acc_illegal` and enables no lane.
- R3: Specifier `10b111` is direct mode. The address is the extension word, with bit 3 (`b`) selecting byte (1) or word (0). The access takes 1 extra clock.
- R4: Specifier `01brrr` (other than `011111` and `010111`) is indirect mode. The address is the value of pointer 8+rrr, with no update and 1 extra clock.
- R5: Specifier `10brrr` with rrr≠7 is auto-increment mode. The address is pointer 8+rrr. The pointer is written back plus 1 for a byte access or plus 2 for a word access, modulo 2^16. The access takes 2 extra clocks. `ptr_upd_idx` carries rrr.
- R6: Specifier `11brrr` is indexed mode. The address is the pointer plus the extension word, modulo 2^16. No pointer is updated, including register 15, and the access takes 3 extra clocks.
- R7: Specifier `010111` is stack access through register 15. A write uses address R15−2 and writes R15−2 back. A read uses address R15 and writes R15+2 back. Either takes 2 extra clocks, with `ptr_upd_idx`=7.
- R8: Lane enables (bit 1 = high byte) are nonzero only for legal RAM writes. A word write enables 2'b11 at an even address, since address bit 0 is forced to 0 for words. A byte write enables 2'b01 at an even address and 2'b10 at an odd address.
- R9: Outputs are registered, one cycle after the request. During reset, and in any cycle after `op_valid` was low, `acc_valid` and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operand request this cycle |
| op_field | input | 6 | Operand specifier |
| op_write | input | 1 | 1 = operand is written (destination) |
| ext_word | input | 16 | Extension word following the instruction |
| bank_base | input | 16 | Register bank base address |
| ptr_vals | input | 128 | Pointers 8..15, pointer 8+i at bits [16i+15:16i] |
| acc_valid | output | 1 | Result valid |
| acc_addr | output | 16 | RAM byte address |
| acc_byte | output | 1 | 1 = byte access |
| lane_we | output | 2 | Write enables {high, low} |
| mem_access | output | 1 | Operand lives in RAM |
| ext_used | output | 1 | Extension word consumed |
| ptr_upd_en | output | 1 | Pointer write-back enable |
| ptr_upd_idx | output | 3 | Pointer index (register 8+idx) |
| ptr_upd_val | output | 16 | New pointer value |
| acc_illegal | output | 1 | Illegal use of the specifier |
| extra_clk | output | 2 | Extra clocks for this operand |

## Verification
The properties assume that `op_valid` is 0 throughout reset. They also assume that `op_field`, `op_write` and the data inputs are stable around the sampling edge, so `$past` of a request always refers to a fully defined specifier. The bench drives every input on the falling edge, holds `op_valid` low for the whole reset and for idle gaps, and uses only fixed, defined pointer and base values. Every property therefore sees clean, single-cycle requests.

// File: rtl/oag_pkg.sv
package oag_pkg;
  localparam int OAG_W   = 16;
  localparam int FIELD_W = 6;
  localparam int REGN_W  = 4;
  localparam int CLK_W   = 2;

  typedef logic [OAG_W-1:0] word_t;

  typedef enum logic [2:0] {
    MD_REG  = 3'd0,
    MD_IMM  = 3'd1,
    MD_DIR  = 3'd2,
    MD_IND  = 3'd3,
    MD_AINC = 3'd4,
    MD_IDX  = 3'd5,
    MD_STK  = 3'd6
  } mode_e;

  // Register n lives at base[15:5] | (n << 1), bit 0 clear
  function automatic word_t bank_reg_addr(input word_t base, input logic [REGN_W-1:0] n);
    word_t a;
    a = base & ~word_t'((1 << (REGN_W + 1)) - 1);
    a = a | (word_t'(n) << 1);
    return a;
  endfunction

  function automatic word_t step_size(input logic is_byte);
    return is_byte ? word_t'(1) : word_t'(2);
  endfunction

  function automatic logic [CLK_W-1:0] extra_clocks(input mode_e m);
    logic [CLK_W-1:0] c;
    case (m)
      MD_DIR, MD_IND:  c = 2'd1;
      MD_AINC, MD_STK: c = 2'd2;
      MD_IDX:          c = 2'd3;
      default:         c = 2'd0;
    endcase
    return c;
  endfunction

  function automatic logic [1:0] lane_mask(input logic mem, input logic wr, input logic bad,
                                           input logic is_byte, input logic a0);
    logic [1:0] m;
    if (!(mem && wr && !bad)) m = 2'b00;
    else if (!is_byte)        m = 2'b11;
    else if (a0)              m = 2'b10;
    else                      m = 2'b01;
    return m;
  endfunction
endpackage

// File: rtl/oag_mode_decode.sv
module oag_mode_decode
  import oag_pkg::*;
#(
  parameter int PTR_SEL_W = 3
) (
  input  logic [FIELD_W-1:0]   field,
  output mode_e                mode,
  output logic                 is_byte,
  output logic [REGN_W-1:0]    reg_num,
  output logic [PTR_SEL_W-1:0] ptr_sel
);
  logic [1:0] cls;
  logic       low_all_ones;

  assign cls          = field[5:4];
  assign low_all_ones = &field[2:0];
  assign reg_num      = field[3:0];
  assign ptr_sel      = PTR_SEL_W'(field[2:0]);

  always_comb begin
    is_byte = field[3];
    mode    = MD_REG;
    unique case (cls)
      2'b00: begin
        mode    = MD_REG;
        is_byte = 1'b0;
      end
      2'b01: begin
        if (low_all_ones && field[3]) begin
          mode    = MD_IMM;
          is_byte = 1'b0;
        end else if (low_all_ones) begin
          mode = MD_STK;
        end else begin
          mode = MD_IND;
        end
      end
      2'b10: mode = low_all_ones ? MD_DIR : MD_AINC;
      default: mode = MD_IDX;
    endcase
  end
endmodule

// File: rtl/oag_ptr_select.sv
module oag_ptr_select
  import oag_pkg::*;
#(
  parameter int NUM_PTR   = 8,
  parameter int PTR_SEL_W = 3
) (
  input  logic [NUM_PTR*OAG_W-1:0] ptr_flat,
  input  logic [PTR_SEL_W-1:0]     sel,
  output word_t                    value
);
  word_t bank [NUM_PTR];

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_unpack
    assign bank[g] = ptr_flat[g*OAG_W +: OAG_W];
  end

  assign value = bank[sel];
endmodule

// File: rtl/oag_addr_calc.sv
module oag_addr_calc
  import oag_pkg::*;
(
  input  mode_e             mode,
  input  logic              is_byte,
  input  logic              wr,
  input  logic [REGN_W-1:0] reg_num,
  input  word_t             ptr,
  input  word_t             ext,
  input  word_t             base,
  output word_t             addr,
  output logic              upd_en,
  output word_t             upd_val,
  output logic              uses_ext,
  output logic              mem,
  output logic              bad
);
  word_t raw;

  always_comb begin
    raw      = '0;
    upd_en   = 1'b0;
    upd_val  = '0;
    uses_ext = 1'b0;
    mem      = 1'b1;
    bad      = 1'b0;
    unique case (mode)
      MD_REG: raw = bank_reg_addr(base, reg_num);
      MD_IMM: begin
        mem      = 1'b0;
        uses_ext = 1'b1;
        bad      = wr;
      end
      MD_DIR: begin
        raw      = ext;
        uses_ext = 1'b1;
      end
      MD_IND: raw = ptr;
      MD_AINC: begin
        raw     = ptr;
        upd_en  = 1'b1;
        upd_val = ptr + step_size(is_byte);
      end
      MD_IDX: begin
        raw      = ptr + ext;
        uses_ext = 1'b1;
      end
      MD_STK: begin
        upd_en = 1'b1;
        if (wr) begin
          raw     = ptr - step_size(1'b0);
          upd_val = ptr - step_size(1'b0);
        end else begin
          raw     = ptr;
          upd_val = ptr + step_size(1'b0);
        end
      end
      default: raw = '0;
    endcase
    addr = is_byte ? raw : {raw[OAG_W-1:1], 1'b0};
  end
endmodule

// File: rtl/oag_top.sv
module oag_top
  import oag_pkg::*;
#(
  parameter int NUM_PTR   = 8,
  localparam int PTR_SEL_W = $clog2(NUM_PTR)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     op_valid,
  input  logic [FIELD_W-1:0]       op_field,
  input  logic                     op_write,
  input  logic [OAG_W-1:0]         ext_word,
  input  logic [OAG_W-1:0]         bank_base,
  input  logic [NUM_PTR*OAG_W-1:0] ptr_vals,
  output logic                     acc_valid,
  output logic [OAG_W-1:0]         acc_addr,
  output logic                     acc_byte,
  output logic [1:0]               lane_we,
  output logic                     mem_access,
  output logic                     ext_used,
  output logic                     ptr_upd_en,
  output logic [PTR_SEL_W-1:0]     ptr_upd_idx,
  output logic [OAG_W-1:0]         ptr_upd_val,
  output logic                     acc_illegal,
  output logic [CLK_W-1:0]         extra_clk
);
  // Named decode events, visible to the bound checker
  mode_e                dec_mode;
  logic                 dec_byte;
  logic [REGN_W-1:0]    dec_reg;
  logic [PTR_SEL_W-1:0] dec_psel;
  word_t                sel_ptr;
  word_t                calc_addr;
  logic                 calc_upd_en;
  word_t                calc_upd_val;
  logic                 calc_ext;
  logic                 calc_mem;
  logic                 calc_bad;
  logic [1:0]           calc_lanes;
  logic [CLK_W-1:0]     calc_clk;

  oag_mode_decode #(.PTR_SEL_W(PTR_SEL_W)) u_dec (
    .field   (op_field),
    .mode    (dec_mode),
    .is_byte (dec_byte),
    .reg_num (dec_reg),
    .ptr_sel (dec_psel)
  );

  oag_ptr_select #(.NUM_PTR(NUM_PTR), .PTR_SEL_W(PTR_SEL_W)) u_psel (
    .ptr_flat (ptr_vals),
    .sel      (dec_psel),
    .value    (sel_ptr)
  );

  oag_addr_calc u_calc (
    .mode     (dec_mode),
    .is_byte  (dec_byte),
    .wr       (op_write),
    .reg_num  (dec_reg),
    .ptr      (sel_ptr),
    .ext      (ext_word),
    .base     (bank_base),
    .addr     (calc_addr),
    .upd_en   (calc_upd_en),
    .upd_val  (calc_upd_val),
    .uses_ext (calc_ext),
    .mem      (calc_mem),
    .bad      (calc_bad)
  );

  assign calc_lanes = lane_mask(calc_mem, op_write, calc_bad, dec_byte, calc_addr[0]);
  assign calc_clk   = extra_clocks(dec_mode);

  always_ff @(posedge clk) begin
    if (!rst_n || !op_valid) begin
      acc_valid   <= 1'b0;
      acc_addr    <= '0;
      acc_byte    <= 1'b0;
      lane_we     <= 2'b00;
      mem_access  <= 1'b0;
      ext_used    <= 1'b0;
      ptr_upd_en  <= 1'b0;
      ptr_upd_idx <= '0;
      ptr_upd_val <= '0;
      acc_illegal <= 1'b0;
      extra_clk   <= '0;
    end else begin
      acc_valid   <= 1'b1;
      acc_addr    <= calc_addr;
      acc_byte    <= dec_byte;
      lane_we     <= calc_lanes;
      mem_access  <= calc_mem;
      ext_used    <= calc_ext;
      ptr_upd_en  <= calc_upd_en;
      ptr_upd_idx <= calc_upd_en ? dec_psel : '0;
      ptr_upd_val <= calc_upd_val;
      acc_illegal <= calc_bad;
      extra_clk   <= calc_clk;
    end
  end
endmodule

// File: rtl/oag_checker.sv
module oag_checker
  import oag_pkg::*;
#(
  parameter int PTR_SEL_W = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 op_valid,
  input logic [FIELD_W-1:0]   op_field,
  input logic                 op_write,
  input logic                 acc_valid,
  input logic [OAG_W-1:0]     acc_addr,
  input logic                 acc_byte,
  input logic [1:0]           lane_we,
  input logic                 mem_access,
  input logic                 ptr_upd_en,
  input logic [PTR_SEL_W-1:0] ptr_upd_idx,
  input logic                 acc_illegal,
  input logic [CLK_W-1:0]     extra_clk
);
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> acc_valid);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!acc_valid && lane_we == 2'b00 && !ptr_upd_en));

  a_r8_read_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_write) |=> lane_we == 2'b00);

  a_r8_byte_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_byte) |-> $countones(lane_we) <= 1);

  a_r8_word_even: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_byte) |-> !acc_addr[0]);

  a_r2_imm_dest_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_write && op_field == 6'b011111) |=> (acc_illegal && !mem_access && lane_we == 2'b00));

  a_r1_reg_word: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_field[5:4] == 2'b00) |=> (!acc_byte && !ptr_upd_en && extra_clk == 2'd0 && mem_access));

  a_r6_index_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_field[5:4] == 2'b11) |=> (!ptr_upd_en && extra_clk == 2'd3));

  a_r7_stack_update: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_field == 6'b010111) |=> (ptr_upd_en && ptr_upd_idx == PTR_SEL_W'(7) && extra_clk == 2'd2));
endmodule

bind oag_top oag_checker #(.PTR_SEL_W(PTR_SEL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid    (op_valid),
  .op_field    (op_field),
  .op_write    (op_write),
  .acc_valid   (acc_valid),
  .acc_addr    (acc_addr),
  .acc_byte    (acc_byte),
  .lane_we     (lane_we),
  .mem_access  (mem_access),
  .ptr_upd_en  (ptr_upd_en),
  .ptr_upd_idx (ptr_upd_idx),
  .acc_illegal (acc_illegal),
  .extra_clk   (extra_clk)
);

// File: tb/oag_top_tb.sv
`timescale 1ns/1ps
module oag_top_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic [5:0]   op_field = '0;
  logic         op_write = 1'b0;
  logic [15:0]  ext_word = '0;
  logic [15:0]  bank_base = 16'h0117;
  logic [127:0] ptr_vals;
  logic         acc_valid, acc_byte, mem_access, ext_used, ptr_upd_en, acc_illegal;
  logic [15:0]  acc_addr, ptr_upd_val;
  logic [1:0]   lane_we, extra_clk;
  logic [2:0]   ptr_upd_idx;
  int           n_checks = 0;
  int           n_fails = 0;
  bit           finished = 0;

  always #2.5 clk = ~clk;

  oag_top u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_field(op_field),
    .op_write(op_write), .ext_word(ext_word), .bank_base(bank_base),
    .ptr_vals(ptr_vals), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_byte(acc_byte), .lane_we(lane_we), .mem_access(mem_access),
    .ext_used(ext_used), .ptr_upd_en(ptr_upd_en), .ptr_upd_idx(ptr_upd_idx),
    .ptr_upd_val(ptr_upd_val), .acc_illegal(acc_illegal), .extra_clk(extra_clk)
  );

  typedef struct packed {
    logic [5:0]  fld;
    logic        wr;
    logic [15:0] ext;
    logic [15:0] addr;
    logic        byt;
    logic [1:0]  lanes;
    logic        upd;
    logic [2:0]  idx;
    logic [15:0] uval;
    logic        ill;
    logic [1:0]  clks;
    logic        mem;
    logic        uext;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [0:NV-1] = '{
    '{6'b001110,1'b0,16'h0000,16'h011C,1'b0,2'b00,1'b0,3'd0,16'h0000,1'b0,2'd0,1'b1,1'b0},
    '{6'b000011,1'b1,16'h0000,16'h0106,1'b0,2'b11,1'b0,3'd0,16'h0000,1'b0,2'd0,1'b1,1'b0},
    '{6'b011111,1'b0,16'hBEEF,16'h0000,1'b0,2'b00,1'b0,3'd0,16'h0000,1'b0,2'd0,1'b0,1'b1},
    '{6'b011111,1'b1,16'hBEEF,16'h0000,1'b0,2'b00,1'b0,3'd0,16'h0000,1'b1,2'd0,1'b0,1'b1},
    '{6'b100111,1'b1,16'h1235,16'h1234,1'b0,2'b11,1'b0,3'd0,16'h0000,1'b0,2'd1,1'b1,1'b1},
    '{6'b101111,1'b1,16'h1235,16'h1235,1'b1,2'b10,1'b0,3'd0,16'h0000,1'b0,2'd1,1'b1,1'b1},
    '{6'b010001,1'b0,16'h0000,16'h3000,1'b0,2'b00,1'b0,3'd0,16'h0000,1'b0,2'd1,1'b1,1'b0},
    '{6'b011001,1'b1,16'h0000,16'h3001,1'b1,2'b10,1'b0,3'd0,16'h0000,1'b0,2'd1,1'b1,1'b0},
    '{6'b011010,1'b1,16'h0000,16'h4002,1'b1,2'b01,1'b0,3'd0,16'h0000,1'b0,2'd1,1'b1,1'b0},
    '{6'b100000,1'b0,16'h0000,16'h2000,1'b0,2'b00,1'b1,3'd0,16'h2002,1'b0,2'd2,1'b1,1'b0},
    '{6'b101110,1'b1,16'h0000,16'hFFFF,1'b1,2'b10,1'b1,3'd6,16'h0000,1'b0,2'd2,1'b1,1'b0},
    '{6'b110011,1'b0,16'h0010,16'h5014,1'b0,2'b00,1'b0,3'd0,16'h0000,1'b0,2'd3,1'b1,1'b1},
    '{6'b111110,1'b1,16'h0003,16'h0002,1'b1,2'b01,1'b0,3'd0,16'h0000,1'b0,2'd3,1'b1,1'b1},
    '{6'b110111,1'b0,16'h0004,16'h0FF4,1'b0,2'b00,1'b0,3'd0,16'h0000,1'b0,2'd3,1'b1,1'b1},
    '{6'b010111,1'b1,16'h0000,16'h0FEE,1'b0,2'b11,1'b1,3'd7,16'h0FEE,1'b0,2'd2,1'b1,1'b0},
    '{6'b010111,1'b0,16'h0000,16'h0FF0,1'b0,2'b00,1'b1,3'd7,16'h0FF2,1'b0,2'd2,1'b1,1'b0},
    '{6'b001111,1'b0,16'h0000,16'h011E,1'b0,2'b00,1'b0,3'd0,16'h0000,1'b0,2'd0,1'b1,1'b0},
    '{6'b010001,1'b1,16'h0000,16'h3000,1'b0,2'b11,1'b0,3'd0,16'h0000,1'b0,2'd1,1'b1,1'b0}
  };
  // Requirement covered by each row: R1 R1 R2 R2 R3 R3 R4 R8 R8 R5 R5 R6 R6 R6 R7 R7 R1 R8
  localparam string TAGS [0:NV-1] = '{"R1","R1","R2","R2","R3","R3","R4","R8","R8",
                                      "R5","R5","R6","R6","R6","R7","R7","R1","R8"};

  function automatic logic [66:0] observed();
    vec_t o;
    o.fld = op_field; o.wr = op_write; o.ext = ext_word;
    o.addr = acc_addr; o.byt = acc_byte; o.lanes = lane_we; o.upd = ptr_upd_en;
    o.idx = ptr_upd_idx; o.uval = ptr_upd_val; o.ill = acc_illegal;
    o.clks = extra_clk; o.mem = mem_access; o.uext = ext_used;
    return o;
  endfunction

  task automatic check(input string tag, input logic [66:0] got, input logic [66:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic request(input logic [5:0] f, input logic w, input logic [15:0] e);
    @(negedge clk);
    op_valid = 1'b1; op_field = f; op_write = w; ext_word = e;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  endtask

  initial begin
    // pointers 8..15
    ptr_vals = {16'h0FF0, 16'hFFFF, 16'h7008, 16'h6006, 16'h5004, 16'h4002, 16'h3001, 16'h2000};
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", {acc_valid, observed() & 67'h0_0000_7FFF_FFFF_FFFF_FFFF}, 68'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      request(v.fld, v.wr, v.ext);
      check(TAGS[i], {acc_valid, observed()}, {1'b1, v});
    end

    // R9: idle request leaves outputs quiet
    @(negedge clk); op_valid = 1'b0; op_write = 1'b1; op_field = 6'b010111;
    @(negedge clk);
    check("R9", {acc_valid, lane_we, ptr_upd_en, acc_addr}, 20'h0);

    // R1: base low bits ignored with a different base
    bank_base = 16'hABCD;
    request(6'b000000, 1'b0, 16'h0);
    check("R1", {acc_valid, acc_addr}, {1'b1, 16'hABC0});
    request(6'b000111, 1'b1, 16'h0);
    check("R1", {acc_addr, lane_we}, {16'hABCE, 2'b11});

    // R7: push wraps below zero
    ptr_vals[127:112] = 16'h0000;
    request(6'b010111, 1'b1, 16'h0);
    check("R7", {acc_addr, ptr_upd_val, ptr_upd_en}, {16'hFFFE, 16'hFFFE, 1'b1});

    // R5: word auto-increment wraps
    request(6'b100110, 1'b0, 16'h0);
    check("R5", {acc_addr, ptr_upd_val, ptr_upd_idx}, {16'hFFFE, 16'h0001, 3'd6});

    @(negedge clk); op_valid = 1'b0;
    summary();
  end

  initial begin
    #(5.0 * 20000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end
endmodule